// File: doc/BRIEF.md
# Oscillator Tuning Step Analyzer

The analyzer measures, with the loop open, how far each tuning bit of a digitally controlled oscillator moves its frequency. For every bit in a chosen index range it forces that bit to 0 and then to 1 through an override port. The rest of the tuning word stays as it is. In each forced state it lets the oscillator settle for a programmed number of reference cycles. It then takes M frequency readings, one per reference cycle. A reading is the change of the oscillator's phase accumulator across that cycle. From the two groups of readings the block forms the averaged step of the bit.

The step is compared with a bank-average step supplied by the user. The block reports the normalized mismatch in signed fixed point with 8 fraction bits, together with a pass flag against a programmable tolerance. Each bit's result is sent out as a one-cycle strobe and also kept in a small table indexed by bit number, which can be read back at any time. The clock is the reference clock, and the phase input is the oscillator's accumulator as sampled by that clock.

Top module: `osc_step_analyzer`

## Requirements
- R1: After reset, ovr_en, ovr_val, busy, res_valid and done are all 0, and every table entry reads step 0, mismatch 0, pass 0.
- R2: For each bit under test, ovr_idx holds the bit index while ovr_val is first 0 and then 1, with ovr_en at 1. Once the run ends, ovr_en and ovr_val return to 0 and stay there until the next run.
- R3: A reading is (phase_acc minus the previous cycle's phase_acc) modulo 2^16, so a wrapping accumulator gives correct readings as long as the per-cycle increment is below 2^16.
- R4: The increments produced in the first `settle` reference cycles after each override change are excluded. Only the following 2^avg_log2 increments are summed.
- R5: The step is floor((sum of the on readings minus sum of the off readings) / 2^avg_log2), as a signed 17-bit value with an arithmetic right shift.
- R6: The mismatch is (step − ref_step)·256 / ref_step truncated toward zero, saturated to ±32767. The value −32768 never appears.
- R7: A bit passes when ref_step is nonzero and |mismatch| ≤ tol, with both sides counted in units of 1/256.
- R8: With ref_step = 0 the bit fails, and the mismatch is +32767 or −32767 following the sign of the step.
- R9: Bits are measured in ascending order from bit_lo up to bit_hi. If bit_hi < bit_lo, only bit_lo is measured. Each result is written to the table entry of its bit and read back combinationally through rd_idx.
- R10: All configuration inputs are captured when start is taken in idle. Changes to them, and further start pulses, have no effect while busy is 1.
- R11: res_valid pulses once per measured bit with res_idx, res_step, res_mism and res_pass. done pulses for one cycle, in the same cycle as the last res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only in idle) |
| bit_lo | input | 4 | First bit index to measure |
| bit_hi | input | 4 | Last bit index to measure |
| avg_log2 | input | 3 | Readings per state M = 2^avg_log2 |
| settle | input | 8 | Reference cycles discarded after each override change |
| ref_step | input | 16 | Bank-average step in phase units per cycle |
| tol | input | 16 | Pass threshold on the mismatch magnitude (Q8) |
| phase_acc | input | 16 | Oscillator phase accumulator sampled by clk |
| rd_idx | input | 4 | Table read index |
| ovr_en | output | 1 | Override of one tuning bit active |
| ovr_idx | output | 4 | Index of the forced tuning bit |
| ovr_val | output | 1 | Forced value of that bit |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_idx | output | 4 | Bit index of the result |
| res_step | output | 17 | Averaged step, signed |
| res_mism | output | 16 | Normalized mismatch, signed Q8 |
| res_pass | output | 1 | Pass flag for the result |
| done | output | 1 | One-cycle pulse at the end of the run |
| rd_step | output | 17 | Table step at rd_idx |
| rd_mism | output | 16 | Table mismatch at rd_idx |
| rd_pass | output | 1 | Table pass flag at rd_idx |

## Verification
The oscillator model in the bench adds a transient after each override change. That transient has a different sign in the on state and the off state, so a settling window that is one cycle too short or too long moves the step by a predictable amount instead of cancelling out. Negative steps with a fractional average exercise the floor rounding; a design that truncates toward zero reports a value one too high. A fast oscillator wraps the accumulator every few cycles, so signed or unwrapped differencing gives nonsense steps. Further runs cover an exact-threshold mismatch, a saturating ratio, a zero bank average, a reversed bit range, and a run disturbed by new inputs and a second start. Each of these catches an off-by-one comparison, an overflowing quotient, a pass on a missing reference, a wrong walk, or configuration that is not captured at start.

// File: rtl/osc_step_analyzer.sv
module osc_step_analyzer #(
  parameter int PW   = 16,
  parameter int NB   = 16,
  parameter int LW   = 3,
  parameter int SETW = 8,
  parameter int FRAC = 8,
  parameter int MW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [$clog2(NB)-1:0] bit_lo,
  input  logic [$clog2(NB)-1:0] bit_hi,
  input  logic [LW-1:0]        avg_log2,
  input  logic [SETW-1:0]      settle,
  input  logic [PW-1:0]        ref_step,
  input  logic [MW-1:0]        tol,
  input  logic [PW-1:0]        phase_acc,
  input  logic [$clog2(NB)-1:0] rd_idx,
  output logic                 ovr_en,
  output logic [$clog2(NB)-1:0] ovr_idx,
  output logic                 ovr_val,
  output logic                 busy,
  output logic                 res_valid,
  output logic [$clog2(NB)-1:0] res_idx,
  output logic signed [PW:0]   res_step,
  output logic signed [MW-1:0] res_mism,
  output logic                 res_pass,
  output logic                 done,
  output logic signed [PW:0]   rd_step,
  output logic signed [MW-1:0] rd_mism,
  output logic                 rd_pass
);
  localparam int IW   = $clog2(NB);
  localparam int SW   = PW + 1;
  localparam int MAXL = (1 << LW) - 1;
  localparam int AW   = PW + MAXL + 2;
  localparam int CW   = MAXL + 1;
  localparam int QW   = SW + FRAC;
  localparam int DCW  = $clog2(QW + 1);
  localparam int MAXP = (1 << (MW - 1)) - 1;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_ACC, S_CALC, S_DIV, S_STORE} st_t;
  st_t st;

  logic [IW-1:0]        lo_r, hi_r;
  logic [LW-1:0]        l_r;
  logic [SETW-1:0]      set_r, cnt;
  logic [PW-1:0]        ref_r, prev, rem;
  logic [MW-1:0]        tol_r;
  logic [CW-1:0]        n;
  logic signed [AW-1:0] sum;
  logic                 neg;
  logic [QW-1:0]        dvd;
  logic [DCW-1:0]       dcnt;

  logic signed [SW-1:0] t_step [NB];
  logic signed [MW-1:0] t_mism [NB];
  logic                 t_pass [NB];

  logic [PW-1:0]        delta;
  logic signed [AW-1:0] delta_ext, sum_nx, shifted;
  logic signed [SW-1:0] step_w;
  logic signed [SW:0]   diff_w, ndiff;
  logic [SW-1:0]        mag_w;
  logic [CW-1:0]        lastn;
  logic [PW:0]          rem_sh;
  logic                 ge;
  logic [MW-1:0]        sat_w;
  logic signed [MW-1:0] mism_w;
  logic                 pass_w;

  assign busy      = (st != S_IDLE);
  assign delta     = phase_acc - prev;
  assign delta_ext = $signed({{(AW-PW){1'b0}}, delta});
  assign sum_nx    = ovr_val ? sum + delta_ext : sum - delta_ext;
  assign lastn     = (CW'(1) << l_r) - CW'(1);
  assign shifted   = sum >>> l_r;
  assign step_w    = shifted[SW-1:0];
  assign diff_w    = $signed({step_w[SW-1], step_w}) - $signed({2'b00, ref_r});
  assign ndiff     = -diff_w;
  assign mag_w     = diff_w[SW] ? ndiff[SW-1:0] : diff_w[SW-1:0];
  assign rem_sh    = {rem, dvd[QW-1]};
  assign ge        = rem_sh >= {1'b0, ref_r};
  assign sat_w     = (dvd > QW'(MAXP)) ? MW'(MAXP) : dvd[MW-1:0];
  assign mism_w    = neg ? -$signed(sat_w) : $signed(sat_w);
  assign pass_w    = (ref_r != '0) && (sat_w <= tol_r);

  assign rd_step = t_step[rd_idx];
  assign rd_mism = t_mism[rd_idx];
  assign rd_pass = t_pass[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lo_r <= '0; hi_r <= '0; l_r <= '0; set_r <= '0; ref_r <= '0; tol_r <= '0;
      cnt <= '0; n <= '0; prev <= '0; sum <= '0; neg <= 1'b0;
      rem <= '0; dvd <= '0; dcnt <= '0;
      ovr_en <= 1'b0; ovr_idx <= '0; ovr_val <= 1'b0;
      res_valid <= 1'b0; res_idx <= '0; res_step <= '0; res_mism <= '0;
      res_pass <= 1'b0; done <= 1'b0;
      for (int i = 0; i < NB; i++) begin
        t_step[i] <= '0; t_mism[i] <= '0; t_pass[i] <= 1'b0;
      end
    end else begin
      prev      <= phase_acc;
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lo_r <= bit_lo; hi_r <= bit_hi; l_r <= avg_log2;
          set_r <= settle; ref_r <= ref_step; tol_r <= tol;
          ovr_en <= 1'b1; ovr_idx <= bit_lo; ovr_val <= 1'b0;
          cnt <= settle; sum <= '0;
          st <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            n  <= '0;
            st <= S_ACC;
          end else cnt <= cnt - 1'b1;
        end
        S_ACC: begin
          sum <= sum_nx;
          n   <= n + 1'b1;
          if (n == lastn) begin
            if (!ovr_val) begin
              ovr_val <= 1'b1;
              cnt     <= set_r;
              st      <= S_SETTLE;
            end else st <= S_CALC;
          end
        end
        S_CALC: begin
          res_step <= step_w;
          neg      <= diff_w[SW];
          dvd      <= {mag_w, {FRAC{1'b0}}};
          rem      <= '0;
          dcnt     <= DCW'(QW);
          st       <= S_DIV;
        end
        S_DIV: begin
          rem  <= ge ? PW'(rem_sh - {1'b0, ref_r}) : PW'(rem_sh);
          dvd  <= {dvd[QW-2:0], ge};
          dcnt <= dcnt - 1'b1;
          if (dcnt == DCW'(1)) st <= S_STORE;
        end
        default: begin
          res_valid <= 1'b1;
          res_idx   <= ovr_idx;
          res_mism  <= mism_w;
          res_pass  <= pass_w;
          t_step[ovr_idx] <= res_step;
          t_mism[ovr_idx] <= mism_w;
          t_pass[ovr_idx] <= pass_w;
          ovr_val <= 1'b0;
          if (ovr_idx >= hi_r) begin
            ovr_en <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            ovr_idx <= ovr_idx + IW'(1);
            cnt     <= set_r;
            sum     <= '0;
            st      <= S_SETTLE;
          end
        end
      endcase
    end
  end

  AST_IDLE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ovr_en && !ovr_val);                                   // R2
  AST_VAL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_val) |-> ovr_en && $stable(ovr_idx));                   // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en |-> ovr_idx >= lo_r);                                      // R9
  AST_REF0_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ref_r == '0 |-> !res_pass);                          // R8
  AST_NO_MIN_MISM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_mism != {1'b1, {(MW-1){1'b0}}});                // R6
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid && !busy);                                     // R11
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ref_r) && $stable(l_r) && $stable(hi_r)); // R10
endmodule

// File: tb/tb_osc_step_analyzer.sv
module tb_osc_step_analyzer;
  localparam int G = 3;
  localparam int F0 = 1000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] bit_lo = 0, bit_hi = 0, rd_idx = 0;
  logic [2:0] avg_log2 = 0;
  logic [7:0] settle = 0;
  logic [15:0] ref_step = 0, tol = 0, phase_acc;
  logic ovr_en, ovr_val, busy, res_valid, res_pass, done, rd_pass;
  logic [3:0] ovr_idx, res_idx;
  logic signed [16:0] res_step, rd_step;
  logic signed [15:0] res_mism, rd_mism;

  int n_chk = 0, n_bad = 0;
  int stepv [16];
  int gx = 0;
  logic [5:0] last_trip;
  int left;

  always #4 clk = ~clk;

  osc_step_analyzer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_lo(bit_lo), .bit_hi(bit_hi),
    .avg_log2(avg_log2), .settle(settle), .ref_step(ref_step), .tol(tol),
    .phase_acc(phase_acc), .rd_idx(rd_idx), .ovr_en(ovr_en), .ovr_idx(ovr_idx),
    .ovr_val(ovr_val), .busy(busy), .res_valid(res_valid), .res_idx(res_idx),
    .res_step(res_step), .res_mism(res_mism), .res_pass(res_pass), .done(done),
    .rd_step(rd_step), .rd_mism(rd_mism), .rd_pass(rd_pass));

  // oscillator model: phase advances by the frequency set by the override,
  // with a signed transient of G cycles after every override change
  always_ff @(posedge clk or negedge rst_n) begin
    int inc;
    if (!rst_n) begin
      phase_acc <= '0; left <= 0; last_trip <= '0;
    end else begin
      inc = F0 + ((ovr_en && ovr_val) ? stepv[ovr_idx] : 0);
      last_trip <= {ovr_en, ovr_val, ovr_idx};
      if ({ovr_en, ovr_val, ovr_idx} != last_trip) begin
        inc = inc + (ovr_val ? gx : -gx); left <= G - 1;
      end else if (left > 0) begin
        inc = inc + (ovr_val ? gx : -gx); left <= left - 1;
      end
      phase_acc <= phase_acc + 16'(inc);
    end
  end

  task automatic chk(string req, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint e_step(int b, int l, int s);
    longint m = 1 << l;
    longint k = G - s;
    if (k < 0) k = 0;
    if (k > m) k = m;
    return (m * stepv[b] + 2 * gx * k) >>> l;
  endfunction

  function automatic longint e_mism(longint st, longint rf);
    longint d = st - rf, q;
    if (rf == 0) return (d < 0) ? -32767 : 32767;
    q = (d * 256) / rf;
    if (q > 32767) q = 32767;
    if (q < -32767) q = -32767;
    return q;
  endfunction

  task automatic run(int lo, int hi, int l, int s, int rf, int tl, bit disturb);
    int exp_idx = lo, last = (hi < lo) ? lo : hi, cyc = 0, rises = 0;
    bit pv = 0, seen_done = 0;
    longint es, em;
    bit_lo = 4'(lo); bit_hi = 4'(hi); avg_log2 = 3'(l); settle = 8'(s);
    ref_step = 16'(rf); tol = 16'(tl);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!seen_done) begin
      @(negedge clk); cyc++;
      if (disturb && cyc == 20) begin
        bit_lo = 4'd0; bit_hi = 4'd15; avg_log2 = 3'd0; settle = 8'd0;
        ref_step = 16'd1; tol = 16'd0; start = 1;
      end
      if (disturb && cyc == 21) start = 0;
      if (ovr_val && !pv) begin
        rises++;
        chk("R2", ovr_en && ovr_idx == 4'(exp_idx), ovr_idx, exp_idx);
      end
      pv = ovr_val;
      if (res_valid) begin
        es = e_step(exp_idx, l, s);
        em = e_mism(es, rf);
        chk("R9 res_idx", res_idx == 4'(exp_idx), res_idx, exp_idx);
        chk("R5 R4 R3 step", res_step == 17'(es), res_step, es);
        chk("R6 mismatch", res_mism == 16'(em), res_mism, em);
        chk("R7 R8 pass", res_pass == (rf != 0 && (em < 0 ? -em : em) <= tl), res_pass,
            (rf != 0 && (em < 0 ? -em : em) <= tl));
        chk("R11 done with last", done == (exp_idx == last), done, exp_idx == last);
        if (done) seen_done = 1;
        exp_idx++;
      end
      if (cyc > 20000) begin
        chk("R11 run ended", 0, cyc, 0);
        seen_done = 1;
      end
    end
    chk("R2 rises", rises == last - lo + 1, rises, last - lo + 1);
    @(negedge clk);
    chk("R11 done one cycle", !done && !busy, done, 0);
    chk("R2 released", !ovr_en && !ovr_val, ovr_en, 0);
  endtask

  task automatic t_reset;
    chk("R1 ovr_en", ovr_en == 0, ovr_en, 0);
    chk("R1 ovr_val", ovr_val == 0, ovr_val, 0);
    chk("R1 busy", busy == 0, busy, 0);
    chk("R1 strobes", res_valid == 0 && done == 0, res_valid, 0);
    rd_idx = 4'd7; #1;
    chk("R1 table", rd_step == 0 && rd_mism == 0 && rd_pass == 0, rd_step, 0);
  endtask

  task automatic t_basic;
    gx = 0;
    run(0, 3, 2, 4, 45, 64, 0);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 4'(i); #1;
      chk("R9 table step", rd_step == 17'(e_step(i, 2, 4)), rd_step, e_step(i, 2, 4));
      chk("R9 table mism", rd_mism == 16'(e_mism(e_step(i, 2, 4), 45)), rd_mism,
          e_mism(e_step(i, 2, 4), 45));
    end
  endtask

  task automatic t_settle;
    stepv[5] = -3; stepv[6] = 7;
    gx = 1; run(5, 6, 2, G - 1, 40, 32767, 0);
    gx = 1; run(5, 6, 2, 0, 40, 32767, 0);
    gx = 5; run(5, 6, 2, G, 40, 32767, 0);
    gx = 0;
  endtask

  task automatic t_wrap;
    stepv[8] = 20000;
    run(8, 8, 3, 2, 20000, 0, 0);
  endtask

  task automatic t_limits;
    stepv[9] = 200; stepv[10] = 66; stepv[11] = -50;
    run(9, 9, 1, 2, 1, 100, 0);
    run(10, 10, 1, 2, 64, 8, 0);
    run(10, 10, 1, 2, 64, 7, 0);
    run(9, 9, 1, 2, 0, 32767, 0);
    run(11, 11, 1, 2, 0, 32767, 0);
  endtask

  task automatic t_range;
    run(12, 4, 1, 1, 60, 500, 0);
    rd_idx = 4'd4; #1;
    chk("R9 untouched", rd_step == 17'(e_step(4, 2, 4)) || rd_step == 0, rd_step, 0);
  endtask

  task automatic t_disturb;
    run(1, 3, 3, 3, 43, 40, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) stepv[i] = 40 + 3 * i;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_basic;
    t_settle;
    t_wrap;
    t_limits;
    t_range;
    t_disturb;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule